// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This unit carries out the stack-side work of a small 8-bit controller core. It performs five multicycle operations: storing one byte on the stack, retrieving one byte, a short call that reaches anywhere inside the current 2 KiB page, a long call to any 16-bit address, and a return. A return-from-interrupt variant is also provided. The unit holds the 8-bit stack pointer and the 16-bit program counter. It reaches the stack through a single-port, byte-wide RAM port with a one-cycle read latency.

The core pulses `start_i` for one cycle and presents the operation code, the opcode byte, the two following instruction bytes, the instruction length and, for a store, the data byte. The unit latches what it needs and raises `busy_o`. It then sequences the RAM accesses and pulses `done_o` for one cycle. In that cycle the stack pointer, the program counter and any retrieved byte are final. The stack grows toward higher addresses and wraps modulo 256. The unit has no status flags and changes none.

Top module: `stk_seq`

## Requirements
- R1: While and after reset, `sp_o` is 0x07, `pc_o` is 0x0000, and `busy_o`, `done_o`, `iret_o` and `ram_we_o` are all 0.
- R2: Operation code 0 (store byte) first increments SP by one. It then writes `push_dat_i` at the new SP and adds `len_i` to PC. `done_o` rises in the 2nd cycle after the start cycle.
- R3: Operation code 1 (retrieve byte) reads the byte at the current SP and presents it on `pop_dat_o` while `done_o` is high. It then decrements SP by one and adds `len_i` to PC. `done_o` rises in the 3rd cycle after the start cycle.
- R4: Operation code 2 (short call) requires the low five opcode bits to be 1 0001. The return address is PC+2. The new PC takes bits 15..11 from the return address, bits 10..8 from opcode bits 7..5, and bits 7..0 from the first operand byte. `done_o` rises in the 3rd cycle.
- R5: Operation code 3 (long call) uses PC+3 as the return address. The new PC is {first operand byte, second operand byte}. `done_o` rises in the 3rd cycle.
- R6: A call writes the return address low byte at SP+1 and then the high byte at SP+2, so SP ends two higher.
- R7: Operation code 4 (return) reads the PC high byte at SP and the low byte at SP-1, so SP ends two lower. `done_o` rises in the 5th cycle.
- R8: Operation code 5 behaves exactly as code 4. It also drives `iret_o` high in the `done_o` cycle. `iret_o` stays 0 for every other operation.
- R9: The following starts are ignored and leave SP, PC and the RAM untouched: a start while `busy_o` is high, an operation code of 6 or 7, and a short call whose opcode low bits differ from 1 0001.
- R10: SP wraps modulo 256. A store at SP 0xFF writes address 0x00, and a retrieve at SP 0x00 leaves SP at 0xFF.
- R11: `done_o` is high for exactly one cycle per operation. `busy_o` is high from the cycle after the start through the `done_o` cycle. `ram_we_o` is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle launch pulse |
| op_i | input | 3 | Operation code (0 store, 1 retrieve, 2 short call, 3 long call, 4 return, 5 interrupt return) |
| opc_i | input | 8 | Opcode byte of the instruction |
| b1_i | input | 8 | First operand byte |
| b2_i | input | 8 | Second operand byte |
| len_i | input | 2 | Instruction length for store and retrieve |
| push_dat_i | input | 8 | Byte to store |
| pop_dat_o | output | 8 | Retrieved byte, valid with done |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| iret_o | output | 1 | Interrupt-return strobe |
| sp_o | output | 8 | Stack pointer |
| pc_o | output | 16 | Program counter |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 8 | RAM address |
| ram_wdat_o | output | 8 | RAM write data |
| ram_rdat_i | input | 8 | RAM read data, one cycle after the address |

## Verification
A stack pointer that is off by one would appear at the completion pulse of the same operation. It would show in `sp_o`, and in the RAM address of the very next access, which the RAM image then records. A byte-order or address-merge fault in a call shows as a wrong `pc_o` in the done cycle. The matching return then shows it again, when it restores a different address. A state-machine slip moves `done_o` or `busy_o` away from the fixed latency of each operation, and the per-cycle comparison catches that in the cycle where it happens.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int PCW  = 2 * DW;
  localparam int PG_W = 11;
  localparam int HI_W = PG_W - DW;
  localparam int OPW  = 3;
  localparam int LENW = 2;
  localparam logic [4:0] NEAR_TAG = 5'b10001;

  typedef enum logic [OPW-1:0] {
    OP_PUSH   = 3'd0,
    OP_POP    = 3'd1,
    OP_CALL11 = 3'd2,
    OP_CALL16 = 3'd3,
    OP_RET    = 3'd4,
    OP_RETI   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_LO, ST_WR_HI, ST_RD_A0, ST_RD_D0, ST_RD_A1, ST_RD_D1, ST_FIN
  } st_e;

  function automatic logic op_known(input logic [OPW-1:0] c);
    return c <= 3'd5;
  endfunction

  // PC after the instruction has been stepped over
  function automatic logic [PCW-1:0] pc_step(input logic [OPW-1:0] c,
                                             input logic [LENW-1:0] len,
                                             input logic [PCW-1:0] pc);
    logic [PCW-1:0] r;
    case (c)
      OP_PUSH, OP_POP: r = pc + {{(PCW-LENW){1'b0}}, len};
      OP_CALL11:       r = pc + PCW'(2);
      OP_CALL16:       r = pc + PCW'(3);
      default:         r = pc;
    endcase
    return r;
  endfunction

  // short call: upper page bits survive from the stepped PC
  function automatic logic [PCW-1:0] near_target(input logic [PCW-1:0] ret,
                                                 input logic [HI_W-1:0] hi,
                                                 input logic [DW-1:0] lo);
    return {ret[PCW-1:PG_W], hi, lo};
  endfunction

  function automatic logic [PCW-1:0] far_target(input logic [DW-1:0] hi,
                                                input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/stk_sp.sv
module stk_sp import stk_pkg::*; #(
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_up
);
  assign sp_up = sp + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= SP_RESET;
    else if (inc) sp <= sp_up;
    else if (dec) sp <= sp - AW'(1);
  end

  a_r11_sp_one_way: assert property (@(posedge clk) disable iff (!rst_n) inc |-> !dec);
  a_r10_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && sp == '0) |=> sp == '1);
  a_r10_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && sp == '1) |=> sp == '0);
endmodule

// File: rtl/stk_pc.sv
module stk_pc import stk_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv_en,
  input  logic [PCW-1:0] adv_val,
  input  logic           ld_en,
  input  logic [PCW-1:0] ld_val,
  output logic [PCW-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (ld_en)  pc <= ld_val;
    else if (adv_en) pc <= adv_val;
  end

  a_r9_pc_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |-> !ld_en);
endmodule

// File: rtl/stk_ctl.sv
module stk_ctl import stk_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  opc_i,
  output logic           accept_o,
  output st_e            st_o,
  output op_e            op_q_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           iret_o
);
  st_e st, st_n;
  op_e op_q;
  logic tag_ok;

  assign tag_ok   = (op_i != OP_CALL11) || (opc_i[4:0] == NEAR_TAG);
  assign busy_o   = (st != ST_IDLE);
  assign accept_o = start_i && !busy_o && op_known(op_i) && tag_ok;
  assign done_o   = (st == ST_FIN);
  assign iret_o   = done_o && (op_q == OP_RETI);
  assign st_o     = st;
  assign op_q_o   = op_q;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:  if (accept_o)
                  st_n = (op_i == OP_POP || op_i == OP_RET || op_i == OP_RETI) ? ST_RD_A0 : ST_WR_LO;
      ST_WR_LO: st_n = (op_q == OP_PUSH) ? ST_FIN : ST_WR_HI;
      ST_WR_HI: st_n = ST_FIN;
      ST_RD_A0: st_n = ST_RD_D0;
      ST_RD_D0: st_n = (op_q == OP_POP) ? ST_FIN : ST_RD_A1;
      ST_RD_A1: st_n = ST_RD_D1;
      ST_RD_D1: st_n = ST_FIN;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      op_q <= OP_PUSH;
    end else begin
      st <= st_n;
      if (accept_o) op_q <= op_e'(op_i);
    end
  end

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(op_q));
  a_r8_iret_with_done: assert property (@(posedge clk) disable iff (!rst_n) iret_o |-> done_o);
  a_r11_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !busy_o);
endmodule

// File: rtl/stk_seq.sv
module stk_seq import stk_pkg::*; #(
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [DW-1:0]   opc_i,
  input  logic [DW-1:0]   b1_i,
  input  logic [DW-1:0]   b2_i,
  input  logic [LENW-1:0] len_i,
  input  logic [DW-1:0]   push_dat_i,
  output logic [DW-1:0]   pop_dat_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            iret_o,
  output logic [AW-1:0]   sp_o,
  output logic [PCW-1:0]  pc_o,
  output logic            ram_we_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdat_o,
  input  logic [DW-1:0]   ram_rdat_i
);
  st_e st;
  op_e op_q;
  logic accept;
  logic [AW-1:0] sp_up;
  logic [HI_W-1:0] hi3_q;
  logic [DW-1:0] b1_q, b2_q, dat_q, hold_q;

  // named internal events
  logic ev_wr_lo, ev_wr_hi, ev_wr, ev_rd_issue, ev_rd_first, ev_rd_last, ev_rd_take, ev_ld;
  logic [PCW-1:0] adv_val, ld_val;

  assign ev_wr_lo    = (st == ST_WR_LO);
  assign ev_wr_hi    = (st == ST_WR_HI);
  assign ev_wr       = ev_wr_lo || ev_wr_hi;
  assign ev_rd_issue = (st == ST_RD_A0) || (st == ST_RD_A1);
  assign ev_rd_first = (st == ST_RD_D0);
  assign ev_rd_last  = (st == ST_RD_D1);
  assign ev_rd_take  = ev_rd_first || ev_rd_last;
  assign ev_ld       = ev_wr_hi || ev_rd_last;

  stk_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .opc_i(opc_i),
    .accept_o(accept), .st_o(st), .op_q_o(op_q),
    .busy_o(busy_o), .done_o(done_o), .iret_o(iret_o)
  );

  stk_sp #(.SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .inc(ev_wr), .dec(ev_rd_take), .sp(sp_o), .sp_up(sp_up)
  );

  assign adv_val = pc_step(op_i, len_i, pc_o);

  always_comb begin
    if (ev_rd_last)              ld_val = far_target(hold_q, ram_rdat_i);
    else if (op_q == OP_CALL11)  ld_val = near_target(pc_o, hi3_q, b1_q);
    else                         ld_val = far_target(b1_q, b2_q);
  end

  stk_pc u_pc (
    .clk(clk), .rst_n(rst_n), .adv_en(accept), .adv_val(adv_val),
    .ld_en(ev_ld), .ld_val(ld_val), .pc(pc_o)
  );

  assign ram_we_o   = ev_wr;
  assign ram_addr_o = ev_wr ? sp_up : sp_o;
  assign ram_wdat_o = ev_wr_hi ? pc_o[PCW-1:DW]
                    : (op_q == OP_PUSH) ? dat_q : pc_o[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi3_q <= '0; b1_q <= '0; b2_q <= '0; dat_q <= '0;
      hold_q <= '0; pop_dat_o <= '0;
    end else begin
      if (accept) begin
        hi3_q <= opc_i[DW-1 -: HI_W];
        b1_q  <= b1_i;
        b2_q  <= b2_i;
        dat_q <= push_dat_i;
      end
      if (ev_rd_first) begin
        hold_q <= ram_rdat_i;
        if (op_q == OP_POP) pop_dat_o <= ram_rdat_i;
      end
    end
  end

  a_r6_write_lands_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> sp_o == $past(ram_addr_o));
  a_r7_read_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_issue |-> (ram_addr_o == sp_o) && !ram_we_o);
  a_r11_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> busy_o);
  a_r2_pc_frozen_midway: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ev_ld) |=> $stable(pc_o));
endmodule

// File: tb/stk_seq_tb.sv
module stk_seq_tb;
  logic clk = 0, rst_n = 0, start_i = 0;
  logic [2:0] op_i = 0;
  logic [7:0] opc_i = 0, b1_i = 0, b2_i = 0, push_dat_i = 0;
  logic [1:0] len_i = 0;
  logic [7:0] pop_dat_o, sp_o, ram_addr_o, ram_wdat_o, ram_rdat_i;
  logic busy_o, done_o, iret_o, ram_we_o;
  logic [15:0] pc_o;
  int total = 0, bad = 0;

  logic [7:0] mem [256];
  logic [7:0] mm  [256];
  logic [7:0] m_sp = 8'h07;
  logic [15:0] m_pc = 16'h0000;

  always #2 clk = ~clk;

  stk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .opc_i(opc_i),
    .b1_i(b1_i), .b2_i(b2_i), .len_i(len_i), .push_dat_i(push_dat_i),
    .pop_dat_o(pop_dat_o), .busy_o(busy_o), .done_o(done_o), .iret_o(iret_o),
    .sp_o(sp_o), .pc_o(pc_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
    .ram_wdat_o(ram_wdat_o), .ram_rdat_i(ram_rdat_i)
  );

  always @(posedge clk) begin
    if (ram_we_o) mem[ram_addr_o] <= ram_wdat_o;
    ram_rdat_i <= mem[ram_addr_o];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int op, input logic [7:0] opc, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [1:0] len,
                       input logic [7:0] dat, input bit inject);
    int lat;
    logic [15:0] r;
    logic [7:0] e_pop, a0, a1;
    bit wr;
    wr = 0; e_pop = 8'h00; a0 = 0; a1 = 0;
    case (op)
      0: begin m_sp = m_sp + 8'd1; mm[m_sp] = dat; a0 = m_sp; a1 = m_sp; wr = 1;
               m_pc = m_pc + 16'(len); lat = 2; end
      1: begin e_pop = mm[m_sp]; m_sp = m_sp - 8'd1; m_pc = m_pc + 16'(len); lat = 3; end
      2, 3: begin
        r = m_pc + ((op == 2) ? 16'd2 : 16'd3);
        a0 = m_sp + 8'd1; a1 = m_sp + 8'd2; wr = 1;
        mm[a0] = r[7:0]; mm[a1] = r[15:8]; m_sp = a1;
        if (op == 2) m_pc = (r & 16'hF800) | (16'(opc >> 5) << 8) | 16'(b1);
        else         m_pc = (16'(b1) << 8) | 16'(b2);
        lat = 3;
      end
      default: begin
        r = (16'(mm[m_sp]) << 8) | 16'(mm[m_sp - 8'd1]);
        m_sp = m_sp - 8'd2; m_pc = r; lat = 5;
      end
    endcase
    @(negedge clk);
    start_i = 1; op_i = 3'(op); opc_i = opc; b1_i = b1; b2_i = b2; len_i = len; push_dat_i = dat;
    @(negedge clk);
    start_i = 0;
    for (int k = 1; k <= lat; k++) begin
      if (k > 1) @(negedge clk);
      start_i = 0;
      chk($sformatf("R11 busy op%0d k%0d", op, k), busy_o, 1);
      chk($sformatf("R11 done op%0d k%0d", op, k), done_o, (k == lat));
      chk($sformatf("R8 iret op%0d k%0d", op, k), iret_o, (k == lat) && (op == 5));
      if (k == 1 && inject) begin start_i = 1; op_i = 3'd1; end
      if (k == lat) begin
        chk($sformatf("R2/R3/R6/R7 sp op%0d", op), sp_o, m_sp);
        chk($sformatf("R4/R5/R7 pc op%0d", op), pc_o, m_pc);
        if (op == 1) chk("R3 pop data", pop_dat_o, e_pop);
        if (wr) begin
          chk($sformatf("R6 ram lo op%0d", op), mem[a0], mm[a0]);
          chk($sformatf("R6 ram hi op%0d", op), mem[a1], mm[a1]);
        end
      end
    end
    @(negedge clk);
    chk("R11 idle busy", busy_o, 0);
    chk("R11 idle done", done_o, 0);
  endtask

  task automatic do_ignored(input int op, input logic [7:0] opc, input string tag);
    @(negedge clk);
    start_i = 1; op_i = 3'(op); opc_i = opc; len_i = 2'd2;
    @(negedge clk);
    start_i = 0;
    chk({tag, " busy"}, busy_o, 0);
    chk({tag, " we"}, ram_we_o, 0);
    @(negedge clk);
    chk({tag, " sp"}, sp_o, m_sp);
    chk({tag, " pc"}, pc_o, m_pc);
    chk({tag, " done"}, done_o, 0);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; mm[i] = 8'(i) ^ 8'h5A; end
    repeat (3) @(negedge clk);
    chk("R1 sp in reset", sp_o, 8'h07);
    chk("R1 pc in reset", pc_o, 0);
    chk("R1 busy in reset", busy_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sp", sp_o, 8'h07);
    chk("R1 pc", pc_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 iret", iret_o, 0);
    chk("R1 we", ram_we_o, 0);

    do_op(3, 8'h12, 8'h12, 8'h34, 0, 0, 0);        // R5 long call
    do_op(0, 0, 0, 0, 2'd2, 8'hA5, 0);              // R2 store
    do_op(0, 0, 0, 0, 2'd1, 8'h3C, 1);              // R9 start while busy
    do_op(1, 0, 0, 0, 2'd2, 0, 0);                  // R3 retrieve
    do_op(2, 8'hB1, 8'h44, 0, 0, 0, 0);             // R4 short call
    do_op(3, 0, 8'h17, 8'hFE, 0, 0, 0);             // R5 to page edge
    do_op(2, 8'h11, 8'h22, 0, 0, 0, 0);             // R4 page carry kept
    do_op(5, 0, 0, 0, 0, 0, 0);                     // R8 interrupt return
    do_op(4, 0, 0, 0, 0, 0, 0);                     // R7 return
    do_ignored(6, 8'h00, "R9 code6");
    do_ignored(7, 8'h00, "R9 code7");
    do_ignored(2, 8'hB2, "R9 bad short tag");
    for (int i = 0; i < 5; i++) do_op(0, 0, 0, 0, 2'(i), 8'(i * 17 + 3), 0);
    for (int i = 0; i < 5; i++) do_op(1, 0, 0, 0, 2'd1, 0, 0);
    while (m_sp != 8'h00) do_op(1, 0, 0, 0, 2'd2, 0, 0);
    do_op(1, 0, 0, 0, 2'd2, 0, 0);                  // R10 wrap down
    chk("R10 sp after wrap", sp_o, 8'hFF);
    do_op(0, 0, 0, 0, 2'd2, 8'hC3, 0);              // R10 wrap up
    chk("R10 write at 00", mem[0], 8'hC3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule